// File: doc/BRIEF.md
# Receive Descriptor Lookahead DMA Engine

This block manages the receive side of a network controller's host buffer ring. Frame bytes arrive from the receive path and wait in an internal staging queue. The engine keeps polling the current descriptor until the host hands it over. It does not start moving a frame into host memory until a threshold number of bytes has been received or the whole frame is in. When it starts, it looks ahead to the following descriptor in the ring. When a buffer fills and more data is pending, it chains into the next descriptor, making one last ownership check first if the earlier lookahead did not find that descriptor owned. Each filled buffer gets a status word written back, and that write also returns the descriptor to the host.

Host memory is a single synchronous port with 32-bit words. A read returns its data in the cycle after the request. Descriptor `i` takes two words starting at `ring_base_i + 2*i`. The first word is the buffer word address. The second word carries bit 31 ownership (1 = engine owns it), bit 30 start-of-packet, bit 29 end-of-packet, bit 28 buffer error, and bits 15:0 the buffer length in bytes (or a byte count on write-back). Frame data is written one byte per memory word, in bits 7:0, at consecutive word addresses from the buffer pointer. The ring length must be at least 2.

Top module: `rxla_engine`

## Requirements
- R1: The engine reads the current descriptor's status word and, only when bit 31 is 1, reads its pointer word. It caches pointer and length, and the frame's bytes land at consecutive words from that pointer.
- R2: No frame byte is written to host memory until THRESH bytes of that frame (default 64) have been accepted, or the whole frame has been accepted if it is shorter.
- R3: When a frame starts, the engine reads the next ring descriptor. If the host still owns that descriptor, the engine keeps writing into its current buffer until the buffer is full.
- R4: When a buffer fills and the frame continues, the engine chains into the next descriptor if it owns it. If the earlier lookahead did not find it owned, the engine reads the descriptor again first, so ownership granted during the frame is taken up.
- R5: Every status write-back has bit 31 cleared. Bit 30 is set only on the first descriptor of a frame. Bit 29 and the total frame byte count (bits 15:0) go on the last descriptor of the frame. Intermediate descriptors carry the buffer length in bits 15:0.
- R6: If a buffer fills with data pending and the re-read shows the next descriptor host-owned, the engine writes status with bit 28 set and bit 29 clear and raises the sticky output `buf_err_o`. It then discards the rest of the frame and places the next frame from its first byte.
- R7: A frame that exactly fills its last owned buffer ends normally with no error, even when the next descriptor is not owned.
- R8: `rint_o` pulses for one cycle after each end-of-packet write-back. When control bit 5 is 1, it also pulses after a start-of-packet write-back of a frame that spans several buffers.
- R9: After descriptor `ring_len_i-1`, the ring index wraps to descriptor 0.
- R10: Data writes only target a buffer whose descriptor the engine owns, within its length. Status writes only target descriptors the engine owns.
- R11: In reset, `rint_o` and `buf_err_o` are 0. After reset the staging queue is empty, so `rx_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base_i | input | AW | Word address of descriptor 0 |
| ring_len_i | input | IW+1 | Number of descriptors in the ring |
| ctrl_i | input | 8 | Control; bit 5 enables the early start-of-packet interrupt |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Marks the last byte of a frame |
| rx_ready_o | output | 1 | Staging queue can accept a byte |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| rint_o | output | 1 | Receive interrupt pulse |
| buf_err_o | output | 1 | Sticky buffer error flag |

## Verification
A stale lookahead cache or a missed last-chance re-read would show up at the next buffer boundary. It appears either as a wrong buffer error or as data written into a descriptor the host still holds, caught on the very memory write that breaks the ownership or length rule. A wrong start condition shows up on the first data write of a frame, compared with the count of bytes accepted by then. Status encoding faults and a wrong ring index appear on the write-back cycle, as wrong bits or a wrong address, and interrupt faults appear one cycle later on `rint_o`.

// File: rtl/rxla_pkg.sv
`timescale 1ns/1ps
package rxla_pkg;

    localparam int OWN_BIT      = 31;
    localparam int STP_BIT      = 30;
    localparam int ENP_BIT      = 29;
    localparam int ERR_BIT      = 28;
    localparam int EARLY_EN_BIT = 5;

    typedef enum logic [3:0] {
        ST_POLL_ST,
        ST_POLL_ST_W,
        ST_POLL_PT,
        ST_POLL_PT_W,
        ST_WAIT,
        ST_LA_ST,
        ST_LA_ST_W,
        ST_LA_PT,
        ST_LA_PT_W,
        ST_DATA,
        ST_WB,
        ST_DROP
    } rxla_state_e;

    typedef enum logic [1:0] {
        WB_CHAIN,
        WB_END,
        WB_ERR
    } rxla_wb_e;

endpackage

// File: rtl/rxla_stage_fifo.sv
`timescale 1ns/1ps
module rxla_stage_fifo #(
    parameter int DEPTH = 128,
    localparam int PW  = $clog2(DEPTH),
    localparam int LVW = PW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid_i,
    input  logic [7:0]     in_data_i,
    input  logic           in_last_i,
    output logic           in_ready_o,
    input  logic           pop_i,
    output logic [7:0]     head_data_o,
    output logic           head_last_o,
    output logic           empty_o,
    output logic [LVW-1:0] level_o,
    output logic           has_eof_o
);
    typedef struct packed {
        logic [PW-1:0]  wr;
        logic [PW-1:0]  rd;
        logic [LVW-1:0] level;
        logic [LVW-1:0] eofs;
    } fifo_t;

    fifo_t q, n;
    logic [8:0] store_q [DEPTH];
    logic push, pop_ok;

    assign in_ready_o  = (q.level != LVW'(DEPTH));
    assign empty_o     = (q.level == '0);
    assign level_o     = q.level;
    assign has_eof_o   = (q.eofs != '0);
    assign head_data_o = store_q[q.rd][7:0];
    assign head_last_o = store_q[q.rd][8];

    always_comb begin
        n      = q;
        push   = in_valid_i && in_ready_o;
        pop_ok = pop_i && !empty_o;
        if (push)   n.wr = q.wr + PW'(1);
        if (pop_ok) n.rd = q.rd + PW'(1);
        n.level = q.level + LVW'(push) - LVW'(pop_ok);
        n.eofs  = q.eofs + LVW'(push && in_last_i) - LVW'(pop_ok && head_last_o);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_ff @(posedge clk) begin
        if (push) store_q[q.wr] <= {in_last_i, in_data_i};
    end
endmodule

// File: rtl/rxla_ring_step.sv
`timescale 1ns/1ps
module rxla_ring_step #(
    parameter int IW = 4
) (
    input  logic [IW-1:0] idx_i,
    input  logic [IW:0]   ring_len_i,
    output logic [IW-1:0] nxt_idx_o
);
    logic [IW:0] inc;

    always_comb begin
        inc       = {1'b0, idx_i} + (IW+1)'(1);
        nxt_idx_o = (inc >= ring_len_i) ? '0 : inc[IW-1:0];
    end
endmodule

// File: rtl/rxla_ctrl.sv
`timescale 1ns/1ps
module rxla_ctrl
    import rxla_pkg::*;
#(
    parameter int AW = 16,
    parameter int IW = 4,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base_i,
    output logic [IW-1:0] idx_o,
    input  logic [IW-1:0] nxt_idx_i,
    input  logic          early_en_i,
    input  logic          go_i,
    input  logic          fifo_empty_i,
    input  logic [7:0]    fifo_data_i,
    input  logic          fifo_last_i,
    output logic          pop_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [31:0]   mem_wdata_o,
    input  logic [31:0]   mem_rdata_i,
    output logic          rint_o,
    output logic          buf_err_o,
    output logic          dat_wr_o,
    output logic          st_wr_o,
    output logic [AW-1:0] cur_ptr_o,
    output logic [LW-1:0] cur_len_o,
    output logic          cur_own_o
);
    typedef struct packed {
        rxla_state_e   st;
        logic [IW-1:0] idx;
        logic [AW-1:0] cur_ptr;
        logic [LW-1:0] cur_len;
        logic          cur_own;
        logic [AW-1:0] nxt_ptr;
        logic [LW-1:0] nxt_len;
        logic          nxt_own;
        logic [LW-1:0] off;
        logic [LW-1:0] tot;
        logic          first;
        logic          lc;
        rxla_wb_e      kind;
        logic          rint;
        logic          err;
    } ctrl_t;

    ctrl_t q, n;
    logic  unused_rd;

    assign unused_rd = ^mem_rdata_i;
    assign idx_o     = q.idx;
    assign rint_o    = q.rint;
    assign buf_err_o = q.err;
    assign cur_ptr_o = q.cur_ptr;
    assign cur_len_o = q.cur_len;
    assign cur_own_o = q.cur_own;

    function automatic logic [AW-1:0] desc_addr(input logic [IW-1:0] i);
        return ring_base_i + AW'({i, 1'b0});
    endfunction

    always_comb begin
        n           = q;
        n.rint      = 1'b0;
        pop_o       = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        dat_wr_o    = 1'b0;
        st_wr_o     = 1'b0;
        unique case (q.st)
            ST_POLL_ST: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_addr(q.idx) + AW'(1);
                n.st       = ST_POLL_ST_W;
            end
            ST_POLL_ST_W: begin
                if (mem_rdata_i[OWN_BIT]) begin
                    n.cur_len = mem_rdata_i[LW-1:0];
                    n.st      = ST_POLL_PT;
                end else begin
                    n.st = ST_POLL_ST;
                end
            end
            ST_POLL_PT: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_addr(q.idx);
                n.st       = ST_POLL_PT_W;
            end
            ST_POLL_PT_W: begin
                n.cur_ptr = mem_rdata_i[AW-1:0];
                n.cur_own = 1'b1;
                n.st      = ST_WAIT;
            end
            ST_WAIT: begin
                if (go_i) begin
                    n.first = 1'b1;
                    n.tot   = '0;
                    n.off   = '0;
                    n.lc    = 1'b0;
                    n.st    = ST_LA_ST;
                end
            end
            ST_LA_ST: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_addr(nxt_idx_i) + AW'(1);
                n.st       = ST_LA_ST_W;
            end
            ST_LA_ST_W: begin
                n.nxt_own = mem_rdata_i[OWN_BIT];
                n.nxt_len = mem_rdata_i[LW-1:0];
                if (mem_rdata_i[OWN_BIT]) begin
                    n.st = ST_LA_PT;
                end else if (q.lc) begin
                    n.kind = WB_ERR;
                    n.st   = ST_WB;
                end else begin
                    n.st = ST_DATA;
                end
            end
            ST_LA_PT: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_addr(nxt_idx_i);
                n.st       = ST_LA_PT_W;
            end
            ST_LA_PT_W: begin
                n.nxt_ptr = mem_rdata_i[AW-1:0];
                if (q.lc) begin
                    n.kind = WB_CHAIN;
                    n.st   = ST_WB;
                end else begin
                    n.st = ST_DATA;
                end
            end
            ST_DATA: begin
                if (!fifo_empty_i) begin
                    pop_o       = 1'b1;
                    mem_req_o   = 1'b1;
                    mem_we_o    = 1'b1;
                    dat_wr_o    = 1'b1;
                    mem_addr_o  = q.cur_ptr + AW'(q.off);
                    mem_wdata_o = {24'd0, fifo_data_i};
                    n.tot       = q.tot + LW'(1);
                    if (fifo_last_i) begin
                        n.kind = WB_END;
                        n.st   = ST_WB;
                    end else if (q.off + LW'(1) == q.cur_len) begin
                        if (q.nxt_own) begin
                            n.kind = WB_CHAIN;
                            n.st   = ST_WB;
                        end else begin
                            n.lc = 1'b1;
                            n.st = ST_LA_ST;
                        end
                    end else begin
                        n.off = q.off + LW'(1);
                    end
                end
            end
            ST_WB: begin
                mem_req_o             = 1'b1;
                mem_we_o              = 1'b1;
                st_wr_o               = 1'b1;
                mem_addr_o            = desc_addr(q.idx) + AW'(1);
                mem_wdata_o[STP_BIT]  = q.first;
                mem_wdata_o[ENP_BIT]  = (q.kind == WB_END);
                mem_wdata_o[ERR_BIT]  = (q.kind == WB_ERR);
                mem_wdata_o[LW-1:0]   = (q.kind == WB_END) ? q.tot : q.cur_len;
                n.rint    = (q.kind == WB_END) || (q.first && early_en_i && q.kind == WB_CHAIN);
                n.err     = q.err || (q.kind == WB_ERR);
                n.idx     = nxt_idx_i;
                n.first   = 1'b0;
                n.off     = '0;
                n.lc      = 1'b0;
                n.nxt_own = 1'b0;
                unique case (q.kind)
                    WB_CHAIN: begin
                        n.cur_ptr = q.nxt_ptr;
                        n.cur_len = q.nxt_len;
                        n.cur_own = 1'b1;
                        n.st      = ST_DATA;
                    end
                    WB_END: begin
                        n.cur_own = 1'b0;
                        n.st      = ST_POLL_ST;
                    end
                    default: begin
                        n.cur_own = 1'b0;
                        n.st      = ST_DROP;
                    end
                endcase
            end
            ST_DROP: begin
                if (!fifo_empty_i) begin
                    pop_o = 1'b1;
                    if (fifo_last_i) n.st = ST_POLL_ST;
                end
            end
            default: n.st = ST_POLL_ST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_POLL_ST;
            q.kind <= WB_CHAIN;
        end else begin
            q <= n;
        end
    end
endmodule

// File: rtl/rxla_engine.sv
`timescale 1ns/1ps
module rxla_engine
    import rxla_pkg::*;
#(
    parameter int AW     = 16,
    parameter int IW     = 4,
    parameter int LW     = 16,
    parameter int THRESH = 64,
    parameter int DEPTH  = 128,
    localparam int LVW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base_i,
    input  logic [IW:0]   ring_len_i,
    input  logic [7:0]    ctrl_i,
    input  logic          rx_valid_i,
    input  logic [7:0]    rx_data_i,
    input  logic          rx_last_i,
    output logic          rx_ready_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [31:0]   mem_wdata_o,
    input  logic [31:0]   mem_rdata_i,
    output logic          rint_o,
    output logic          buf_err_o
);
    logic [7:0]     head_data;
    logic           head_last;
    logic           fifo_empty;
    logic [LVW-1:0] fifo_level;
    logic           fifo_has_eof;
    logic           fifo_pop;
    logic           fifo_go;
    logic [IW-1:0]  idx;
    logic [IW-1:0]  nxt_idx;
    logic           dat_wr;
    logic           st_wr;
    logic [AW-1:0]  cur_ptr;
    logic [LW-1:0]  cur_len;
    logic           cur_own;
    logic           unused_ctrl;

    assign unused_ctrl = ^(ctrl_i & ~(8'd1 << EARLY_EN_BIT));
    assign fifo_go     = (32'(fifo_level) >= THRESH) || fifo_has_eof;

    rxla_stage_fifo #(.DEPTH(DEPTH)) u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (rx_valid_i),
        .in_data_i   (rx_data_i),
        .in_last_i   (rx_last_i),
        .in_ready_o  (rx_ready_o),
        .pop_i       (fifo_pop),
        .head_data_o (head_data),
        .head_last_o (head_last),
        .empty_o     (fifo_empty),
        .level_o     (fifo_level),
        .has_eof_o   (fifo_has_eof)
    );

    rxla_ring_step #(.IW(IW)) u_step (
        .idx_i      (idx),
        .ring_len_i (ring_len_i),
        .nxt_idx_o  (nxt_idx)
    );

    rxla_ctrl #(.AW(AW), .IW(IW), .LW(LW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ring_base_i  (ring_base_i),
        .idx_o        (idx),
        .nxt_idx_i    (nxt_idx),
        .early_en_i   (ctrl_i[EARLY_EN_BIT]),
        .go_i         (fifo_go),
        .fifo_empty_i (fifo_empty),
        .fifo_data_i  (head_data),
        .fifo_last_i  (head_last),
        .pop_o        (fifo_pop),
        .mem_req_o    (mem_req_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_rdata_i  (mem_rdata_i),
        .rint_o       (rint_o),
        .buf_err_o    (buf_err_o),
        .dat_wr_o     (dat_wr),
        .st_wr_o      (st_wr),
        .cur_ptr_o    (cur_ptr),
        .cur_len_o    (cur_len),
        .cur_own_o    (cur_own)
    );
endmodule

// File: rtl/rxla_engine_chk.sv
`timescale 1ns/1ps
module rxla_engine_chk #(
    parameter int AW = 16,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          rint,
    input logic          buf_err,
    input logic          dat_wr,
    input logic          st_wr,
    input logic [AW-1:0] cur_ptr,
    input logic [LW-1:0] cur_len,
    input logic          cur_own
);
    // R10
    data_in_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr |-> (cur_own && (32'(mem_addr - cur_ptr) < 32'(cur_len))));

    // R5
    status_clears_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |-> !mem_wdata[31]);

    // R8
    rint_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rint |-> $past(st_wr));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_err |=> buf_err);

    // R1
    data_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && $past(dat_wr)) |-> (mem_addr == $past(mem_addr) + AW'(1)));
endmodule

bind rxla_engine rxla_engine_chk #(.AW(AW), .LW(LW)) u_rxla_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr_o),
    .mem_wdata (mem_wdata_o),
    .rint      (rint_o),
    .buf_err   (buf_err_o),
    .dat_wr    (dat_wr),
    .st_wr     (st_wr),
    .cur_ptr   (cur_ptr),
    .cur_len   (cur_len),
    .cur_own   (cur_own)
);

// File: tb/rxla_engine_bench.sv
`timescale 1ns/1ps
module rxla_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ring_base = 16'd0;
    logic [4:0]  ring_len = 5'd4;
    logic [7:0]  ctrl = 8'd0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'd0;
    logic        rx_last = 1'b0;
    logic        rx_ready_o;
    logic        mem_req_o, mem_we_o;
    logic [15:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic [31:0] mem_rdata = 32'd0;
    logic        rint_o, buf_err_o;

    logic [31:0] mem [0:1023];
    int checks = 0, errors = 0;
    int rint_cnt = 0, viol_cnt = 0, thr_viol = 0;
    int fed_cnt = 0, frm_len = 0;
    bit first_wr_seen = 1'b1;

    always #5 clk = ~clk;

    rxla_engine u_rxla_engine (
        .clk(clk), .rst_n(rst_n), .ring_base_i(ring_base), .ring_len_i(ring_len),
        .ctrl_i(ctrl), .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
        .rx_ready_o(rx_ready_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata),
        .rint_o(rint_o), .buf_err_o(buf_err_o)
    );

    // memory model with one-cycle read latency
    always @(posedge clk) begin
        if (mem_req_o) begin
            if (mem_we_o) mem[mem_addr_o[9:0]] <= mem_wdata_o;
            else          mem_rdata <= mem[mem_addr_o[9:0]];
        end
    end

    // ownership, range and start-threshold monitor (R2, R10)
    always @(posedge clk) begin
        if (rst_n && mem_req_o && mem_we_o) begin
            int a, i, o, lim;
            a = int'(mem_addr_o[9:0]);
            if (a >= 256) begin
                i = (a - 256) >> 6;
                o = (a - 256) & 63;
                if (!mem[2*i+1][31] || o >= int'(mem[2*i+1][15:0])) viol_cnt++;
                if (!first_wr_seen) begin
                    first_wr_seen = 1'b1;
                    lim = (frm_len < 64) ? frm_len : 64;
                    if (fed_cnt < lim) thr_viol++;
                end
            end else if (a < 8 && a[0]) begin
                if (!mem[a][31] || mem_wdata_o[31]) viol_cnt++;
            end
        end
        if (rx_valid && rx_ready_o) fed_cnt <= fed_cnt + 1;
    end

    always @(negedge clk) if (rst_n && rint_o) rint_cnt++;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_desc(int i, bit own, bit stp, int len);
        mem[2*i]   = 32'(256 + 64*i);
        mem[2*i+1] = {own, stp, 14'd0, 16'(len)};
    endtask

    task automatic feed(int n, int seed);
        int k = 0;
        frm_len = n;
        fed_cnt = 0;
        first_wr_seen = 1'b0;
        while (k < n) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 8'(seed + k);
            rx_last  = (k == n - 1);
            if (rx_ready_o) k++;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic settle();
        repeat (300) @(negedge clk);
    endtask

    task automatic check_buf(string tag, int d, int first_byte, int nbytes, int seed);
        int bad = 0;
        for (int k = 0; k < nbytes; k++)
            if (mem[256 + 64*d + k][7:0] != 8'(seed + first_byte + k)) bad++;
        chk(tag, bad, 0);
    endtask

    task automatic t_reset();
        chk("R11 rint in reset", int'(rint_o), 0);
        chk("R11 buf_err in reset", int'(buf_err_o), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R11 ready after reset", int'(rx_ready_o), 1);
    endtask

    task automatic t_short();
        ctrl = 8'h00; rint_cnt = 0;
        set_desc(0, 1, 1, 64);
        feed(20, 10); settle();
        chk("R5 short status", int'(mem[1]), 32'h6000_0014);
        check_buf("R1 short data", 0, 0, 20, 10);
        chk("R2 short start", thr_viol, 0);
        chk("R8 short rint", rint_cnt, 1);
    endtask

    task automatic t_chain_early();
        ctrl = 8'h20; rint_cnt = 0;
        set_desc(1, 1, 1, 64); set_desc(2, 1, 0, 64); set_desc(3, 1, 0, 64);
        feed(150, 40); settle();
        chk("R5 sop status", int'(mem[3]), 32'h4000_0040);
        chk("R5 mid status", int'(mem[5]), 32'h0000_0040);
        chk("R5 eop status", int'(mem[7]), 32'h2000_0096);
        check_buf("R4 chain data b1", 1, 0, 64, 40);
        check_buf("R4 chain data b2", 2, 64, 64, 40);
        check_buf("R4 chain data b3", 3, 128, 22, 40);
        chk("R2 long start", thr_viol, 0);
        chk("R8 early rint count", rint_cnt, 2);
    endtask

    task automatic t_late_own();
        ctrl = 8'h00; rint_cnt = 0;
        set_desc(0, 1, 1, 64); set_desc(1, 1, 0, 64); set_desc(2, 0, 0, 64);
        fork
            feed(150, 90);
            begin
                while (mem[1][31]) @(negedge clk);
                mem[5] = {1'b1, 1'b0, 14'd0, 16'd64};
            end
        join
        settle();
        chk("R9 wrap to desc0", int'(mem[1]), 32'h4000_0040);
        chk("R4 late own eop", int'(mem[5]), 32'h2000_0096);
        check_buf("R4 late own data", 2, 128, 22, 90);
        chk("R4 no error", int'(buf_err_o), 0);
        chk("R8 rint without early", rint_cnt, 1);
    endtask

    task automatic t_buf_err();
        ctrl = 8'h00; rint_cnt = 0;
        set_desc(3, 1, 1, 64); set_desc(0, 0, 0, 64);
        feed(100, 120); settle();
        chk("R6 err status", int'(mem[7]), 32'h5000_0040);
        chk("R6 sticky flag", int'(buf_err_o), 1);
        check_buf("R3 kept filling", 3, 0, 64, 120);
        chk("R8 no rint on error", rint_cnt, 0);
    endtask

    task automatic t_resync();
        rint_cnt = 0;
        set_desc(0, 1, 1, 64);
        feed(30, 77); settle();
        chk("R6 resync status", int'(mem[1]), 32'h6000_001E);
        check_buf("R6 resync data", 0, 0, 30, 77);
        chk("R6 flag stays", int'(buf_err_o), 1);
    endtask

    task automatic t_exact();
        rint_cnt = 0;
        set_desc(1, 1, 1, 64); set_desc(2, 0, 0, 64);
        feed(64, 200); settle();
        chk("R7 exact fit status", int'(mem[3]), 32'h6000_0040);
        check_buf("R7 exact fit data", 1, 0, 64, 200);
        chk("R7 exact rint", rint_cnt, 1);
        chk("R10 ownership monitor", viol_cnt, 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 1024; k++) mem[k] = 32'd0;
        repeat (5) @(negedge clk);
        t_reset();
        t_short();
        t_chain_early();
        t_late_own();
        t_buf_err();
        t_resync();
        t_exact();
        finish_run();
    end
endmodule